// File: doc/BRIEF.md
# Dual-Issue Dispatch Stage with Rename Tags

This block sits between an instruction queue and a set of execution units. Each cycle it examines the two oldest queued instructions, which arrive already decoded into an execution-unit class and register numbers. It sends at most two of them, in program order, to their units. A branch from a separate branch slot can leave in the same cycle as a third instruction. The instruction queue learns through `deq_n` how many head entries were taken, and the branch source learns the same through `br_take`.

For every source operand the block works out whether the value already exists. If it does, the value goes out with the instruction, taken from the architectural register file, a written rename register, or the writeback arriving in that same cycle. If it does not, the block sends the index of the rename register that will produce the value. A mapping table records, for each architectural register, the latest rename register allocated to it. Every dispatched instruction takes a completion-queue slot, and every destination takes a rename register. When the completion side retires entries, their rename values are copied into the architectural file and their resources are freed.

Top module: `dual_dispatch`

## Requirements
- R1: At most two non-branch instructions leave per cycle. `deq_n` (combinational, same cycle) gives how many head entries were taken (0, 1 or 2). Lane 0 carries the older instruction. `o_v` shows the dispatched lanes one cycle later.
- R2: Dispatch is in order. If the older head instruction cannot go because its unit is not ready, there is no completion slot, or there is no rename register for its destination, the younger one is also held.
- R3: The two instructions go to different units. If both name the same unit class, only the older one goes.
- R4: When `i_br_v` and `br_rdy` are high, a branch is dispatched in addition to the lanes if one more completion slot is free beyond those the lanes use. Its slot number follows theirs. The branch does not depend on whether the lanes dispatch.
- R5: Completion slots are assigned in ring order, lane 0 first, then lane 1, then the branch. The ring wraps from NC-1 to 0. Nothing is dispatched into a full ring.
- R6: A destination takes the lowest-numbered free rename register. If lane 0 also allocates, lane 1 takes the next free one. An instruction whose destination cannot get a rename register is held.
- R7: A source operand whose register has no pending mapping is sent ready (`o_rdy`=1) with the architectural value. One mapped to a rename register that is already written, or is being written back this cycle, is sent ready with that value.
- R8: Any other source is sent not ready with `o_tag` set to the rename register in the latest mapping. A lane 1 source that names lane 0's destination gets lane 0's new rename register. When both lanes write the same register, lane 1's mapping is kept.
- R9: Retiring `cmt_n` oldest completion entries copies each entry's rename value into its architectural register and frees the rename register. The mapping is cleared only when it still points to that rename register.
- R10: After reset no lane or branch output is valid, no mapping is pending, the completion ring is empty, and architectural register i holds 17*i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| i_v | input | 2 | Head entry valid, bit 0 oldest |
| i_unit | input | 2*UW | Unit class per head entry |
| i_dst_en | input | 2 | Head entry writes a destination |
| i_dst | input | 2*AW | Destination register per head entry |
| i_src | input | 4*AW | Source registers, index lane*2+operand |
| unit_rdy | input | NU | Unit can accept an instruction |
| i_br_v | input | 1 | Branch waiting |
| br_rdy | input | 1 | Branch unit can accept |
| wb_en | input | 1 | Rename register writeback |
| wb_tag | input | RW | Rename register written |
| wb_data | input | W | Value written |
| cmt_n | input | 2 | Completion entries retired this cycle |
| deq_n | output | 2 | Head entries taken this cycle |
| br_take | output | 1 | Branch taken this cycle |
| o_v | output | 2 | Lane dispatched last cycle |
| o_unit | output | 2*UW | Lane unit class |
| o_cq | output | 2*CW | Lane completion slot |
| o_rtag | output | 2*RW | Lane rename register for destination |
| o_dst_en | output | 2 | Lane has a destination |
| o_rdy | output | 4 | Operand carries a value |
| o_data | output | 4*W | Operand value |
| o_tag | output | 4*RW | Operand producer rename register |
| o_br_v | output | 1 | Branch dispatched last cycle |
| o_br_cq | output | CW | Branch completion slot |

## Verification
`deq_n` and `br_take` are decided in the same cycle as the inputs. The bench therefore checks them shortly after driving a negative edge, before the next rising edge. Lane and branch outputs come from one register stage and belong to the instruction offered one edge earlier. The driver queues the expected lane and branch items while it drives, and the monitor takes them off at the following negative edge, once per valid lane. Mapping, writeback and retire effects appear only in operands dispatched after the edge that applied them, so each scenario step is built so that its expected operands depend only on updates made on earlier edges.

// File: rtl/dual_dispatch.sv
module dual_dispatch #(
  parameter int W  = 16,
  parameter int NA = 8,
  parameter int NR = 6,
  parameter int NC = 6,
  parameter int NU = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           i_v,
  input  logic [2*$clog2(NU)-1:0] i_unit,
  input  logic [1:0]           i_dst_en,
  input  logic [2*$clog2(NA)-1:0] i_dst,
  input  logic [4*$clog2(NA)-1:0] i_src,
  input  logic [NU-1:0]        unit_rdy,
  input  logic                 i_br_v,
  input  logic                 br_rdy,
  input  logic                 wb_en,
  input  logic [$clog2(NR)-1:0] wb_tag,
  input  logic [W-1:0]         wb_data,
  input  logic [1:0]           cmt_n,
  output logic [1:0]           deq_n,
  output logic                 br_take,
  output logic [1:0]           o_v,
  output logic [2*$clog2(NU)-1:0] o_unit,
  output logic [2*$clog2(NC)-1:0] o_cq,
  output logic [2*$clog2(NR)-1:0] o_rtag,
  output logic [1:0]           o_dst_en,
  output logic [3:0]           o_rdy,
  output logic [4*W-1:0]       o_data,
  output logic [4*$clog2(NR)-1:0] o_tag,
  output logic                 o_br_v,
  output logic [$clog2(NC)-1:0] o_br_cq
);
  localparam int AW = $clog2(NA);
  localparam int RW = $clog2(NR);
  localparam int CW = $clog2(NC);
  localparam int UW = $clog2(NU);
  localparam int KW = $clog2(NC + 1);

  logic [W-1:0]  arf     [NA];
  logic [NA-1:0] mp_pend;
  logic [RW-1:0] mp_tag  [NA];
  logic [NR-1:0] rb_busy, rb_done;
  logic [W-1:0]  rb_data [NR];
  logic [AW-1:0] rb_areg [NR];
  logic [NC-1:0] cq_dst;
  logic [RW-1:0] cq_tag  [NC];
  logic [CW-1:0] cq_hd, cq_tl;
  logic [KW-1:0] cq_cnt;

  function automatic logic [CW-1:0] wrap(input logic [CW-1:0] p, input logic [1:0] k);
    logic [CW:0] s;
    s = {1'b0, p} + (CW+1)'(k);
    return (s >= (CW+1)'(NC)) ? CW'(s - (CW+1)'(NC)) : CW'(s);
  endfunction

  logic [UW-1:0] u0, u1;
  logic [AW-1:0] d0, d1;
  assign u0 = i_unit[UW-1:0];
  assign u1 = i_unit[2*UW-1:UW];
  assign d0 = i_dst[AW-1:0];
  assign d1 = i_dst[2*AW-1:AW];

  logic [RW-1:0] f0, f1;
  logic [RW:0]   nf;
  always_comb begin
    f0 = '0; f1 = '0; nf = '0;
    for (int i = NR-1; i >= 0; i--)
      if (!rb_busy[i]) begin
        f1 = f0;
        f0 = RW'(i);
        nf = nf + (RW+1)'(1);
      end
  end

  logic [KW-1:0] cq_free;
  logic [1:0]    need;
  logic          go0, go1;
  logic [RW-1:0] rt0, rt1;
  logic [CW-1:0] c0, c1, cb;
  assign cq_free = KW'(NC) - cq_cnt;
  assign need    = {1'b0, i_dst_en[0]} + {1'b0, i_dst_en[1]};
  assign go0 = i_v[0] && unit_rdy[u0] && cq_free >= KW'(1) && (!i_dst_en[0] || nf >= (RW+1)'(1));
  assign go1 = go0 && i_v[1] && unit_rdy[u1] && (u1 != u0) && cq_free >= KW'(2)
               && nf >= (RW+1)'(need);
  assign deq_n   = go1 ? 2'd2 : (go0 ? 2'd1 : 2'd0);
  assign br_take = i_br_v && br_rdy && (cq_free > KW'(deq_n));
  assign rt0 = f0;
  assign rt1 = i_dst_en[0] ? f1 : f0;
  assign c0  = cq_tl;
  assign c1  = wrap(cq_tl, 2'd1);
  assign cb  = wrap(cq_tl, deq_n);

  logic [3:0]    op_rdy;
  logic [W-1:0]  op_val [4];
  logic [RW-1:0] op_tag [4];
  always_comb begin
    for (int k = 0; k < 4; k++) begin
      logic [AW-1:0] s;
      logic [RW-1:0] t;
      s = i_src[k*AW +: AW];
      t = mp_tag[s];
      op_rdy[k] = 1'b1;
      op_val[k] = arf[s];
      op_tag[k] = '0;
      if (mp_pend[s]) begin
        op_tag[k] = t;
        if (rb_done[t])                  op_val[k] = rb_data[t];
        else if (wb_en && wb_tag == t)   op_val[k] = wb_data;
        else begin op_rdy[k] = 1'b0; op_val[k] = '0; end
      end
      if (k >= 2 && i_dst_en[0] && d0 == s) begin
        op_rdy[k] = 1'b0; op_val[k] = '0; op_tag[k] = rt0;
      end
    end
  end

  logic [CW-1:0] rp  [2];
  logic [1:0]    ret;
  logic [RW-1:0] rtg [2];
  logic [AW-1:0] rar [2];
  always_comb begin
    rp[0] = cq_hd;
    rp[1] = wrap(cq_hd, 2'd1);
    for (int r = 0; r < 2; r++) begin
      ret[r] = (2'(r) < cmt_n) && cq_dst[rp[r]];
      rtg[r] = cq_tag[rp[r]];
      rar[r] = rb_areg[rtg[r]];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NA; i++) begin arf[i] <= W'(17 * i); mp_tag[i] <= '0; end
      for (int i = 0; i < NR; i++) begin rb_data[i] <= '0; rb_areg[i] <= '0; end
      for (int i = 0; i < NC; i++) cq_tag[i] <= '0;
      mp_pend <= '0; rb_busy <= '0; rb_done <= '0; cq_dst <= '0;
      cq_hd <= '0; cq_tl <= '0; cq_cnt <= '0;
      o_v <= '0; o_unit <= '0; o_cq <= '0; o_rtag <= '0; o_dst_en <= '0;
      o_rdy <= '0; o_data <= '0; o_tag <= '0; o_br_v <= 1'b0; o_br_cq <= '0;
    end else begin
      for (int r = 0; r < 2; r++)
        if (ret[r]) begin
          arf[rar[r]]  <= rb_data[rtg[r]];
          rb_busy[rtg[r]] <= 1'b0;
          if (mp_pend[rar[r]] && mp_tag[rar[r]] == rtg[r]) mp_pend[rar[r]] <= 1'b0;
        end
      if (wb_en) begin
        rb_done[wb_tag] <= 1'b1;
        rb_data[wb_tag] <= wb_data;
      end
      if (go0) begin
        cq_dst[c0] <= i_dst_en[0];
        cq_tag[c0] <= rt0;
        if (i_dst_en[0]) begin
          rb_busy[rt0] <= 1'b1; rb_done[rt0] <= 1'b0; rb_areg[rt0] <= d0;
          mp_pend[d0] <= 1'b1; mp_tag[d0] <= rt0;
        end
      end
      if (go1) begin
        cq_dst[c1] <= i_dst_en[1];
        cq_tag[c1] <= rt1;
        if (i_dst_en[1]) begin
          rb_busy[rt1] <= 1'b1; rb_done[rt1] <= 1'b0; rb_areg[rt1] <= d1;
          mp_pend[d1] <= 1'b1; mp_tag[d1] <= rt1;
        end
      end
      if (br_take) cq_dst[cb] <= 1'b0;
      cq_tl  <= wrap(cq_tl, deq_n + {1'b0, br_take});
      cq_hd  <= wrap(cq_hd, cmt_n);
      cq_cnt <= cq_cnt + KW'(deq_n) + KW'(br_take) - KW'(cmt_n);
      o_v      <= {go1, go0};
      o_unit   <= i_unit;
      o_cq     <= {c1, c0};
      o_rtag   <= {rt1, rt0};
      o_dst_en <= i_dst_en & {go1, go0};
      o_rdy    <= op_rdy;
      for (int k = 0; k < 4; k++) begin
        o_data[k*W +: W]  <= op_val[k];
        o_tag[k*RW +: RW] <= op_tag[k];
      end
      o_br_v  <= br_take;
      o_br_cq <= cb;
    end
  end
endmodule

// File: rtl/dispatch_chk.sv
module dispatch_chk #(
  parameter int NU = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [1:0]               i_v,
  input logic [2*$clog2(NU)-1:0]  i_unit,
  input logic [NU-1:0]            unit_rdy,
  input logic                     i_br_v,
  input logic                     br_rdy,
  input logic [1:0]               deq_n,
  input logic                     br_take,
  input logic [1:0]               o_v,
  input logic                     o_br_v
);
  localparam int UW = $clog2(NU);
  logic [UW-1:0] cu0, cu1;
  assign cu0 = i_unit[UW-1:0];
  assign cu1 = i_unit[2*UW-1:UW];

  // R1
  issue_cap_chk: assert property (@(posedge clk) disable iff (!rst_n) deq_n != 2'd3);
  // R1
  lane_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (deq_n == 2'd2) |=> (o_v == 2'b11));
  // R2
  in_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (deq_n == 2'd2) |-> (i_v == 2'b11 && unit_rdy[cu0] && unit_rdy[cu1]));
  // R3
  unit_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (deq_n == 2'd2) |-> (cu0 != cu1));
  // R4
  branch_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    br_take |-> (i_br_v && br_rdy));
  // R4
  branch_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    br_take |=> o_br_v);
endmodule

bind dual_dispatch dispatch_chk #(.NU(NU)) u_chk (.*);

// File: tb/tb_dual_dispatch.sv
module tb_dual_dispatch;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [1:0] i_v, i_dst_en, cmt_n, deq_n, o_v, o_dst_en;
  logic [3:0] i_unit, o_unit, unit_rdy, o_rdy, o_rtag;
  logic [5:0] i_dst, o_cq;
  logic [11:0] i_src;
  logic i_br_v, br_rdy, wb_en, br_take, o_br_v;
  logic [1:0] wb_tag;
  logic [15:0] wb_data;
  logic [63:0] o_data;
  logic [7:0] o_tag;
  logic [2:0] o_br_cq;

  dual_dispatch #(.W(16), .NA(8), .NR(4), .NC(6), .NU(4)) dut (.*);

  typedef struct {
    int lane; int unit; int cq; bit dst; int rtag;
    bit rdy[2]; int val[2]; int tag[2]; string req;
  } item_t;
  item_t sb[$];
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  task automatic fail(string req, string what, int act, int exp);
    n_bad++;
    $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
  endtask

  task automatic clr();
    i_v = 0; i_unit = 0; i_dst_en = 0; i_dst = 0; i_src = 0; unit_rdy = 4'hF;
    i_br_v = 0; br_rdy = 1; wb_en = 0; wb_tag = 0; wb_data = 0; cmt_n = 0;
  endtask

  task automatic setl(int l, int u, bit de, int d, int sa, int sb2);
    i_v[l] = 1; i_unit[l*2 +: 2] = 2'(u); i_dst_en[l] = de; i_dst[l*3 +: 3] = 3'(d);
    i_src[(l*2)*3 +: 3] = 3'(sa); i_src[(l*2+1)*3 +: 3] = 3'(sb2);
  endtask

  task automatic chk(int edeq, bit ebr, string req);
    #1;
    n_cmp++;
    if (deq_n != 2'(edeq) || br_take != ebr)
      fail(req, "deq_n/br_take", {deq_n, br_take}, {2'(edeq), ebr});
  endtask

  task automatic exl(int l, int u, int cq, bit de, int rt,
                     bit ra, int va, bit rb, int vb, string req);
    item_t e;
    e.lane = l; e.unit = u; e.cq = cq; e.dst = de; e.rtag = rt;
    e.rdy[0] = ra; e.val[0] = va; e.tag[0] = va;
    e.rdy[1] = rb; e.val[1] = vb; e.tag[1] = vb;
    e.req = req;
    sb.push_back(e);
  endtask

  task automatic exb(int cq, string req);
    item_t e;
    e.lane = 2; e.cq = cq; e.req = req;
    sb.push_back(e);
  endtask

  always @(negedge clk) if (rst_n) begin
    for (int l = 0; l < 3; l++) begin
      bit v;
      v = (l < 2) ? o_v[l] : o_br_v;
      if (v) begin
        n_cmp++;
        if (sb.size() == 0) fail("R1", "unexpected output lane", l, -1);
        else begin
          item_t e;
          bit bad;
          e = sb.pop_front();
          bad = 0;
          if (e.lane != l) begin bad = 1; fail(e.req, "lane", l, e.lane); end
          else if (l == 2) begin
            if (o_br_cq != 3'(e.cq)) begin bad = 1; fail(e.req, "branch cq", o_br_cq, e.cq); end
          end else begin
            if (o_unit[l*2 +: 2] != 2'(e.unit)) begin bad = 1; fail(e.req, "unit", o_unit[l*2 +: 2], e.unit); end
            if (o_cq[l*3 +: 3] != 3'(e.cq)) begin bad = 1; fail(e.req, "cq", o_cq[l*3 +: 3], e.cq); end
            if (o_dst_en[l] != e.dst) begin bad = 1; fail(e.req, "dst_en", o_dst_en[l], e.dst); end
            if (e.dst && o_rtag[l*2 +: 2] != 2'(e.rtag)) begin bad = 1; fail(e.req, "rtag", o_rtag[l*2 +: 2], e.rtag); end
            for (int s = 0; s < 2; s++) begin
              int k;
              k = l*2 + s;
              if (o_rdy[k] != e.rdy[s]) begin bad = 1; fail(e.req, "operand ready", o_rdy[k], e.rdy[s]); end
              else if (e.rdy[s] && o_data[k*16 +: 16] != 16'(e.val[s])) begin bad = 1; fail(e.req, "operand value", o_data[k*16 +: 16], e.val[s]); end
              else if (!e.rdy[s] && o_tag[k*2 +: 2] != 2'(e.tag[s])) begin bad = 1; fail(e.req, "operand tag", o_tag[k*2 +: 2], e.tag[s]); end
            end
          end
          if (bad) n_cmp = n_cmp + 0;
        end
      end
    end
  end

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #20000;
    fail("R1", "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    clr();
    repeat (3) @(negedge clk);
    n_cmp++;  // R10 reset state
    if (o_v != 0 || o_br_v != 0) fail("R10", "outputs in reset", {o_v, o_br_v}, 0);
    rst_n = 1;

    // S1: two lanes with dependence, plus branch
    @(negedge clk); clr();
    setl(0, 0, 1, 1, 2, 3); setl(1, 1, 1, 4, 1, 5); i_br_v = 1;
    chk(2, 1, "R1 R4");
    exl(0, 0, 0, 1, 0, 1, 'h22, 1, 'h33, "R7 R10");
    exl(1, 1, 1, 1, 1, 0, 0, 1, 'h55, "R8");
    exb(2, "R4");

    // S2: same unit twice, writeback forward
    @(negedge clk); clr();
    setl(0, 2, 1, 1, 1, 4); setl(1, 2, 1, 6, 0, 0);
    wb_en = 1; wb_tag = 1; wb_data = 16'hBEEF;
    chk(1, 0, "R3");
    exl(0, 2, 3, 1, 2, 0, 0, 1, 'hBEEF, "R7");

    // S3: fills ring, branch refused
    @(negedge clk); clr();
    setl(0, 0, 1, 2, 4, 1); setl(1, 3, 0, 0, 2, 7); i_br_v = 1;
    wb_en = 1; wb_tag = 0; wb_data = 16'h1234;
    chk(2, 0, "R4 R5");
    exl(0, 0, 4, 1, 3, 1, 'hBEEF, 0, 2, "R6 R8");
    exl(1, 3, 5, 0, 0, 0, 3, 1, 'h77, "R8");

    // S4: ring full, retire two
    @(negedge clk); clr();
    setl(0, 1, 0, 0, 0, 0); i_br_v = 1; cmt_n = 2;
    chk(0, 0, "R5");

    // S5: ring wrap, rename reuse
    @(negedge clk); clr();
    setl(0, 1, 1, 5, 4, 1); setl(1, 0, 1, 3, 5, 3); i_br_v = 1;
    chk(2, 0, "R5");
    exl(0, 1, 0, 1, 0, 1, 'hBEEF, 0, 2, "R9 R5");
    exl(1, 0, 1, 1, 1, 0, 0, 1, 'h33, "R6");

    // S6: retire branch entry, write rename 2
    @(negedge clk); clr();
    cmt_n = 1; wb_en = 1; wb_tag = 2; wb_data = 16'h2222;
    chk(0, 0, "R9");

    // S7: no rename free, branch alone
    @(negedge clk); clr();
    setl(0, 0, 1, 6, 0, 0); i_br_v = 1;
    wb_en = 1; wb_tag = 3; wb_data = 16'h3333;
    chk(0, 1, "R6 R4");
    exb(2, "R4");

    // S8: retire two
    @(negedge clk); clr();
    cmt_n = 2;
    chk(0, 0, "R9");

    // S9: older unit busy holds both
    @(negedge clk); clr();
    setl(0, 2, 1, 7, 1, 2); setl(1, 0, 1, 7, 7, 6); unit_rdy = 4'b1011;
    chk(0, 0, "R2");

    // S10: same pair released, retire one
    @(negedge clk); clr();
    setl(0, 2, 1, 7, 1, 2); setl(1, 0, 1, 7, 7, 6); cmt_n = 1;
    chk(2, 0, "R2 R9");
    exl(0, 2, 3, 1, 2, 1, 'h2222, 1, 'h3333, "R9");
    exl(1, 0, 4, 1, 3, 0, 2, 1, 'h66, "R8");

    // S11: younger writer of r7 wins
    @(negedge clk); clr();
    setl(0, 1, 0, 0, 7, 3);
    chk(1, 0, "R8");
    exl(0, 1, 5, 0, 0, 0, 3, 0, 1, "R8");

    @(negedge clk); clr();
    @(negedge clk); #1;
    n_cmp++;
    if (sb.size() != 0) fail("R1", "items never produced", sb.size(), 0);
    summary();
  end
endmodule